// File: doc/BRIEF.md
# Prescaled Up/Down Timer with Forced Update

This block is a general-purpose timer counter clocked from the system clock through a programmable divider. The divider produces a one-cycle count tick every (divider value + 1) enabled clock cycles. On each tick the main counter steps up toward a reload limit or down toward zero. When it wraps, the block emits a one-cycle update pulse.

An update can also be forced at any time. Software does this by writing a command bit, and a rising edge on the slave trigger input does the same. A forced update starts a counter-initialize action. This action clears the divider counter and restarts the main counter: at zero when counting up, at the reload limit when counting down. It raises the same update pulse that a natural wrap raises.

Configuration goes through a simple write port: a strobe, a 2-bit address and a data word. Every write is accepted in the cycle its strobe is high, so the port never applies back-pressure. There is no read path. The counter value and the update pulse are plain outputs.

Top module: `tmr_update_timer`

## Requirements
- R1: After reset the count output is 0 and the update output is low. The timer is disabled, counts up, has divider 0, and has a reload limit of all ones.
- R2: While enabled with divider value D, the counter moves exactly once every D+1 clock cycles. A divider counter that is at or above D produces a tick.
- R3: In up mode the counter steps 0, 1, … up to the reload limit L. On the tick after L it returns to 0, and upd_o is high for the one cycle in which the count shows 0.
- R4: In down mode the counter steps down to 0. On the tick after 0 it loads L, and upd_o is high in the cycle that first shows L.
- R5: A write to address 3 with data bit 0 set forces an initialize at that clock edge. In the next cycle the count is 0 in up mode or L in down mode, the divider counter is 0, and upd_o is high. The next tick then comes a full D+1 cycles later.
- R6: A rising edge on trig_i acts exactly like R5. Holding trig_i high triggers only once.
- R7: An initialize at the same edge as a natural wrap gives a single update pulse. The initialize value wins.
- R8: While disabled, neither the counter nor the divider advances. A forced initialize still takes effect.
- R9: The write map is as follows. Address 0 holds the enable in bit 0 and the direction in bit 1 (1 = down). Address 1 holds the divider and address 2 the reload limit. The address-3 command bit is not stored: cycles without a write cause no further initialize.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, always accepted |
| wr_addr | input | 2 | Register address |
| wr_data | input | W | Write data |
| trig_i | input | 1 | Slave trigger, rising edge forces update |
| cnt_o | output | W | Current counter value |
| upd_o | output | 1 | One-cycle update event |

## Verification
The bench forces an initialize on the very edge where the counter wraps. A design that ORs two separate pulse paths badly would emit two pulses, or would let the wrap value win over the initialize value. It forces updates while the timer is disabled, to catch a design that gates the initialize with the enable. It shrinks the divider below the running divider count, to catch a divider that compares for equality and then never ticks again. It holds the trigger high across many cycles, to catch level-sensitive triggering, and it checks that down-mode wraps reload the limit rather than all ones.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_DIV    = 2'd1,
    REG_RELOAD = 2'd2,
    REG_CMD    = 2'd3
  } reg_addr_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_DOWN_BIT = 1;
  localparam int CMD_FORCE_BIT = 0;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         trig_i,
  output logic         cfg_en,
  output logic         cfg_down,
  output logic [W-1:0] cfg_div,
  output logic [W-1:0] cfg_reload,
  output logic         init_o
);
  reg_addr_e addr;
  logic      trig_q;
  logic      sw_force;

  assign addr     = reg_addr_e'(wr_addr);
  // command bit is never stored: it acts only in the cycle it is written
  assign sw_force = wr_en && (addr == REG_CMD) && wr_data[CMD_FORCE_BIT];
  assign init_o   = sw_force || (trig_i && !trig_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en     <= 1'b0;
      cfg_down   <= 1'b0;
      cfg_div    <= '0;
      cfg_reload <= '1;
      trig_q     <= 1'b0;
    end else begin
      trig_q <= trig_i;
      if (wr_en) begin
        case (addr)
          REG_CTRL: begin
            cfg_en   <= wr_data[CTRL_EN_BIT];
            cfg_down <= wr_data[CTRL_DOWN_BIT];
          end
          REG_DIV:    cfg_div    <= wr_data;
          REG_RELOAD: cfg_reload <= wr_data;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] div,
  output logic         tick_o,
  output logic [W-1:0] pc_o
);
  // >= keeps ticking when the divider is lowered below the running count
  assign tick_o = en && (pc_o >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_o <= '0;
    else if (clr)    pc_o <= '0;
    else if (tick_o) pc_o <= '0;
    else if (en)     pc_o <= pc_o + 1'b1;
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         init,
  input  logic         down,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt_o,
  output logic         upd_o
);
  logic         at_edge;
  logic         wrap;
  logic [W-1:0] stepped;

  assign at_edge = down ? (cnt_o == '0) : (cnt_o == reload);
  assign wrap    = tick && at_edge;

  always_comb begin
    if (down) stepped = at_edge ? reload : cnt_o - 1'b1;
    else      stepped = at_edge ? '0     : cnt_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
      upd_o <= 1'b0;
    end else begin
      upd_o <= init || wrap;
      if (init)      cnt_o <= down ? reload : '0;
      else if (tick) cnt_o <= stepped;
    end
  end
endmodule

// File: rtl/tmr_update_timer.sv
module tmr_update_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         trig_i,
  output logic [W-1:0] cnt_o,
  output logic         upd_o
);
  logic         cfg_en;
  logic         cfg_down;
  logic [W-1:0] cfg_div;
  logic [W-1:0] cfg_reload;
  logic         init_pulse;
  logic         cnt_tick;
  logic [W-1:0] psc_cnt;

  tmr_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trig_i(trig_i), .cfg_en(cfg_en),
    .cfg_down(cfg_down), .cfg_div(cfg_div), .cfg_reload(cfg_reload),
    .init_o(init_pulse)
  );

  tmr_prescaler #(.W(W)) u_psc (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .clr(init_pulse),
    .div(cfg_div), .tick_o(cnt_tick), .pc_o(psc_cnt)
  );

  tmr_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .init(init_pulse),
    .down(cfg_down), .reload(cfg_reload), .cnt_o(cnt_o), .upd_o(upd_o)
  );
endmodule

// File: rtl/tmr_update_timer_chk.sv
module tmr_update_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         init,
  input logic         tick,
  input logic [W-1:0] pc,
  input logic         en,
  input logic         down,
  input logic [W-1:0] reload,
  input logic [W-1:0] cnt,
  input logic         upd
);
  // R5
  init_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> upd);

  // R5
  init_psc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (pc == '0));

  // R8
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !init) |=> ($stable(cnt) && $stable(pc)));

  // R3
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !down && cnt == reload && !init) |=> (cnt == '0 && upd));

  // R4
  down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && down && cnt == '0 && !init) |=> (cnt == $past(reload) && upd));

  // R7
  no_spurious_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !tick) |=> !upd);
endmodule

bind tmr_update_timer tmr_update_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .init(init_pulse), .tick(cnt_tick),
  .pc(psc_cnt), .en(cfg_en), .down(cfg_down), .reload(cfg_reload),
  .cnt(cnt_o), .upd(upd_o)
);

// File: tb/tb_tmr_update_timer.sv
module tb_tmr_update_timer;
  localparam int W = 16;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         trig_i = 1'b0;
  logic [W-1:0] cnt_o;
  logic         upd_o;

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  bit    chk_on = 1'b0;
  string cur_req = "R1";

  // reference model state
  logic         m_en, m_down, m_trq, m_upd;
  logic [W-1:0] m_div, m_rel, m_pc, m_cnt;

  tmr_update_timer #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trig_i(trig_i), .cnt_o(cnt_o), .upd_o(upd_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] next_count(logic [W-1:0] c, logic dn,
                                               logic [W-1:0] lim);
    if (dn) return (c == '0) ? lim : c - 1'b1;
    return (c == lim) ? '0 : c + 1'b1;
  endfunction

  function automatic logic is_wrap(logic [W-1:0] c, logic dn, logic [W-1:0] lim);
    return dn ? (c == '0) : (c == lim);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_down = 0; m_trq = 0; m_upd = 0;
      m_div = '0; m_rel = '1; m_pc = '0; m_cnt = '0;
    end else begin
      logic f_init, f_tick;
      f_init = (wr_en && wr_addr == 2'd3 && wr_data[0]) || (trig_i && !m_trq);
      f_tick = m_en && (m_pc >= m_div);
      m_upd  = f_init || (f_tick && is_wrap(m_cnt, m_down, m_rel));
      if (f_init)      m_cnt = m_down ? m_rel : '0;
      else if (f_tick) m_cnt = next_count(m_cnt, m_down, m_rel);
      if (f_init || f_tick) m_pc = '0;
      else if (m_en)        m_pc = m_pc + 1'b1;
      m_trq = trig_i;
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin m_en = wr_data[0]; m_down = wr_data[1]; end
          2'd1: m_div = wr_data;
          2'd2: m_rel = wr_data;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && chk_on && !done) begin
      checks++;
      if (cnt_o !== m_cnt || upd_o !== m_upd) begin
        fails++;
        $display("FAIL %s cnt actual=%0d expected=%0d upd actual=%0b expected=%0b",
                 cur_req, cnt_o, m_cnt, upd_o, m_upd);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_count(logic [W-1:0] v);
    int guard = 0;
    while (m_cnt != v && guard < 1000) begin @(posedge clk); guard++; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (cnt_o !== '0 || upd_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 cnt actual=%0d expected=0 upd actual=%0b expected=0", cnt_o, upd_o);
    end
    chk_on = 1'b1;

    // R2, R3, R9: up count, divider 2, limit 4
    cur_req = "R2";
    wr(2'd1, 16'd2);
    wr(2'd2, 16'd4);
    wr(2'd0, 16'h1);
    idle(20);
    cur_req = "R3";
    idle(40);

    // R4: down mode
    cur_req = "R4";
    wr(2'd0, 16'h3);
    idle(60);

    // R5: software force mid-period, up mode
    cur_req = "R5";
    wr(2'd0, 16'h1);
    idle(7);
    wr(2'd3, 16'h1);
    idle(12);
    wr(2'd0, 16'h3);
    idle(5);
    wr(2'd3, 16'h1);
    idle(15);

    // R9: command bit not held; writes with bit 0 clear do nothing
    cur_req = "R9";
    wr(2'd3, 16'hFFFE);
    idle(20);

    // R6: trigger edge, held high
    cur_req = "R6";
    @(negedge clk); trig_i = 1'b1;
    idle(25);
    trig_i = 1'b0;
    idle(4);
    trig_i = 1'b1;
    idle(3);
    trig_i = 1'b0;

    // R7: force coinciding with natural wrap, divider 0, limit 3, up
    cur_req = "R7";
    wr(2'd1, 16'd0);
    wr(2'd2, 16'd3);
    wr(2'd0, 16'h1);
    wait_count(16'd3);
    @(negedge clk);
    if (m_cnt == 16'd3) begin
      wr_en = 1'b1; wr_addr = 2'd3; wr_data = 16'h1;
      @(negedge clk); wr_en = 1'b0;
    end
    idle(4);
    wait_count(16'd3);
    @(negedge clk); trig_i = 1'b1;
    idle(3); trig_i = 1'b0;

    // R8: disabled hold, force still applies
    cur_req = "R8";
    wr(2'd1, 16'd3);
    wr(2'd0, 16'h1);
    idle(6);
    wr(2'd0, 16'h0);
    idle(10);
    wr(2'd3, 16'h1);
    idle(5);
    wr(2'd0, 16'h2);
    wr(2'd3, 16'h1);
    idle(8);

    // R2: divider lowered below a running divider count
    cur_req = "R2";
    wr(2'd1, 16'd9);
    wr(2'd0, 16'h1);
    idle(7);
    wr(2'd1, 16'd1);
    idle(20);

    // random mix
    cur_req = "R3";
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      int r;
      @(negedge clk);
      r = int'($urandom % 100);
      wr_en = 1'b0;
      if (r < 12) begin
        wr_en = 1'b1;
        wr_addr = 2'($urandom % 4);
        case (wr_addr)
          2'd0: wr_data = W'(($urandom % 4) | (($urandom % 4 != 0) ? 1 : 0));
          2'd1: wr_data = W'($urandom % 4);
          2'd2: wr_data = W'($urandom % 8);
          default: wr_data = W'($urandom % 2);
        endcase
      end
      if (($urandom % 100) < 4) trig_i = ~trig_i;
      cur_req = m_down ? "R4" : "R3";
    end
    @(negedge clk); wr_en = 1'b0; trig_i = 1'b0;
    idle(3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule